// File: doc/BRIEF.md
# Vertical Polyphase Video Scaler

This block changes the number of lines in a video frame while keeping the pixel count per line. Pixels arrive one per clock on a valid/ready stream. Start-of-frame and end-of-line flags travel with the pixels. Each pixel carries three 8-bit colour components. The block stores the latest input lines in a ring of line memories, one memory per filter tap. For every output line it forms a weighted sum of a window of source lines using a multi-tap polyphase filter.

Filter weights are written at any time into a register-side bank. When the first frame after reset begins, the block copies the whole bank into a local coefficient memory. It accepts no pixels until that copy is complete. Later writes to the bank do not reach the filter.

The vertical position of each output line comes from a fixed-point accumulator that advances by a programmed step per output line. Its integer part picks the source window and its upper fraction bits pick the phase. Input and output take turns. After each input line the input is held off for a fixed bookkeeping gap. Output begins only once a tap-count worth of lines has been stored. Output backpressure freezes the output without losing or repeating pixels.

Top module: `vert_poly_scaler`

## Requirements
- R1: After reset, both `s_ready` and `m_valid` are low.
- R2: A start-of-frame pixel presented first after reset is not accepted until at least PHASES*TAPS cycles (384 by default) have passed. During that time every register-bank word is copied to the local coefficient memory. The bank word for phase p and tap t sits at address p*TAPS+t.
- R3: After the pixel carrying `s_eol` is accepted, `s_ready` stays low for at least GAP cycles (default 20).
- R4: The first output pixel of a frame does not appear before min(TAPS, `cfg_in_lines`) input lines have been accepted.
- R5: Output line j is centred on source line floor(j*`cfg_step`/2^16). It uses phase bits [15:10] of the 16-bit fraction of j*`cfg_step`.
- R6: Each output component equals the sum over taps of pixel times coefficient, as signed 16-bit weights with 12 fraction bits. The sum gets 2048 added, is shifted right arithmetically by 12, and is clamped to 0..255. Component c occupies data bits [8c+7:8c].
- R7: Tap t (0..TAPS-1) reads source row centre-(TAPS/2-1)+t. A row above the frame is replaced by row 0, and a row below it by the last row.
- R8: While `m_valid` is high and `m_ready` is low, `m_valid`, `m_data`, `m_sof` and `m_eol` stay unchanged on the next cycle, and no pixel is lost or repeated.
- R9: Each frame yields exactly `cfg_out_lines` lines with as many pixels as the input lines. `m_sof` marks only the first pixel of the frame and `m_eol` marks the last pixel of every line. Input lines are limited to MAX_W pixels.
- R10: Coefficient writes made after the first copy do not change any later output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| coef_wr_en | input | 1 | Register-bank write strobe |
| coef_wr_addr | input | 9 | Bank address, phase*TAPS+tap |
| coef_wr_data | input | 16 | Signed weight, 12 fraction bits |
| cfg_in_lines | input | 11 | Source lines per frame, sampled at frame start |
| cfg_out_lines | input | 11 | Output lines per frame, sampled at frame start |
| cfg_step | input | 27 | Source lines per output line, 16 fraction bits |
| s_valid | input | 1 | Input pixel valid |
| s_ready | output | 1 | Input pixel accepted when high with s_valid |
| s_data | input | 24 | Input pixel, three components |
| s_sof | input | 1 | First pixel of a frame |
| s_eol | input | 1 | Last pixel of a line |
| m_valid | output | 1 | Output pixel valid |
| m_ready | input | 1 | Downstream ready |
| m_data | output | 24 | Output pixel, three components |
| m_sof | output | 1 | First pixel of an output frame |
| m_eol | output | 1 | Last pixel of an output line |

## Verification
A wrong accumulator or phase value shows as wrong component values from the first pixel of the affected output line. A slot-mapping or edge-clamp error corrupts every pixel of lines near the top or bottom edge. A miscounted copy or gap counter changes how many cycles `s_ready` stays low after a frame start or a line end, and shows up within a single line time. Flow-control faults show as missing, duplicated or unstable pixels during a stall. These are caught at the handshake where they occur, against a model that recomputes every pixel from the image and weights written by the bench.

// File: rtl/vsc_pkg.sv
// Package: shared state encoding and helpers for the vertical scaler.
// Assumes: nothing beyond standard integer arithmetic.
package vsc_pkg;

    // Controller phases of a frame
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,   // waiting for a start-of-frame pixel
        ST_COPY = 3'd1,   // loading local coefficient memory
        ST_IN   = 3'd2,   // taking one input line
        ST_GAP  = 3'd3,   // per-line bookkeeping pause
        ST_DEC  = 3'd4,   // choose next activity
        ST_OUT  = 3'd5    // emitting one output line
    } vsc_state_e;

    // Clamp a row index into [0, rows-1]
    function automatic int vsc_clamp_row(input int row, input int rows);
        int r;
        r = row;
        if (r > rows - 1) r = rows - 1;
        if (r < 0) r = 0;
        return r;
    endfunction

endpackage

// File: rtl/vsc_coef_store.sv
// Module: register-side coefficient bank plus local coefficient memory.
// Writes land in the bank at any time; a one-shot copy moves every bank
// word into the local memory, one word per cycle. The filter reads all
// taps of one phase from the local memory combinationally.
// Assumes: copy_start is pulsed only while no copy is running.
module vsc_coef_store #(
    parameter int TAPS   = 6,
    parameter int PHASES = 64,
    parameter int COEF_W = 16,
    parameter int CA_W   = 9,
    parameter int PH_W   = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [CA_W-1:0]          wr_addr,
    input  logic [COEF_W-1:0]        wr_data,
    input  logic                     copy_start,
    output logic                     copy_busy,
    output logic                     copy_last,
    input  logic [PH_W-1:0]          rd_phase,
    output logic [TAPS*COEF_W-1:0]   rd_coefs
);
    localparam int COPY_LEN = PHASES * TAPS;

    logic [COEF_W-1:0] bank [COPY_LEN];
    logic [COEF_W-1:0] loc  [COPY_LEN];
    logic [CA_W-1:0]   cnt;
    logic [CA_W-1:0]   rd_base;

    // Register-side writes, out-of-range addresses dropped
    always_ff @(posedge clk) begin
        if (wr_en && (wr_addr < CA_W'(COPY_LEN))) bank[wr_addr] <= wr_data;
    end

    // Copy sequencer: walk every address once after copy_start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            copy_busy <= 1'b0;
            cnt       <= '0;
        end else if (copy_start) begin
            copy_busy <= 1'b1;
            cnt       <= '0;
        end else if (copy_busy) begin
            if (cnt == CA_W'(COPY_LEN - 1)) copy_busy <= 1'b0;
            else                            cnt <= cnt + CA_W'(1);
        end
    end

    // Local memory fill, one word per busy cycle
    always_ff @(posedge clk) begin
        if (copy_busy) loc[cnt] <= bank[cnt];
    end

    assign copy_last = copy_busy && (cnt == CA_W'(COPY_LEN - 1));
    assign rd_base   = CA_W'(int'(rd_phase) * TAPS);

    // One read port per tap of the selected phase
    for (genvar t = 0; t < TAPS; t++) begin : g_rd
        assign rd_coefs[t*COEF_W +: COEF_W] = loc[rd_base + CA_W'(t)];
    end

    // R2: the copy counter never walks past the last bank word
    a_r2_copy_bound: assert property (@(posedge clk) disable iff (!rst_n)
        copy_busy |-> (cnt < CA_W'(COPY_LEN)));

endmodule

// File: rtl/vsc_line_buf.sv
// Module: ring of line memories, one slot per filter tap.
// One write port stores the incoming pixel; TAPS read ports return the
// same column from the slots chosen by the controller.
// Assumes: the controller never writes a column at or beyond MAX_W.
module vsc_line_buf #(
    parameter int DATA_W = 24,
    parameter int TAPS   = 6,
    parameter int MAX_W  = 64,
    parameter int SLOT_W = 3,
    parameter int X_W    = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [SLOT_W-1:0]        wr_slot,
    input  logic [X_W-1:0]           wr_col,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [TAPS*SLOT_W-1:0]   rd_slots,
    input  logic [X_W-1:0]           rd_col,
    output logic [TAPS*DATA_W-1:0]   rd_data
);
    localparam int DEPTH = TAPS * MAX_W;
    localparam int AW    = $clog2(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_addr;

    assign wr_addr = AW'(int'(wr_slot) * MAX_W + int'(wr_col));

    // Store one incoming pixel
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Read the same column from every tap slot
    for (genvar t = 0; t < TAPS; t++) begin : g_rd
        logic [AW-1:0] rd_addr;
        assign rd_addr = AW'(int'(rd_slots[t*SLOT_W +: SLOT_W]) * MAX_W + int'(rd_col));
        assign rd_data[t*DATA_W +: DATA_W] = mem[rd_addr];
    end

    // R9: writes stay inside the line length limit
    a_r9_col_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_col) < MAX_W));

endmodule

// File: rtl/vsc_filter.sv
// Module: combinational multi-tap vertical filter for all components.
// Sum of pixel times signed weight, round half up, clamp to pixel range.
// Assumes: weights are signed with COEF_FRAC fraction bits.
module vsc_filter #(
    parameter int PIX_W     = 8,
    parameter int COMP      = 3,
    parameter int TAPS      = 6,
    parameter int COEF_W    = 16,
    parameter int COEF_FRAC = 12
) (
    input  logic [TAPS*COMP*PIX_W-1:0] pix,
    input  logic [TAPS*COEF_W-1:0]     coefs,
    output logic [COMP*PIX_W-1:0]      result
);
    localparam int DATA_W = COMP * PIX_W;
    localparam int SUM_W  = PIX_W + 1 + COEF_W + $clog2(TAPS) + 2;

    for (genvar c = 0; c < COMP; c++) begin : g_comp
        logic signed [SUM_W-1:0] sum;
        logic signed [SUM_W-1:0] q;

        // Weighted sum over taps, then rounding shift
        always_comb begin
            logic signed [SUM_W-1:0] pe;
            logic signed [SUM_W-1:0] ce;
            sum = '0;
            for (int t = 0; t < TAPS; t++) begin
                pe  = SUM_W'($signed({1'b0, pix[t*DATA_W + c*PIX_W +: PIX_W]}));
                ce  = SUM_W'($signed(coefs[t*COEF_W +: COEF_W]));
                sum = sum + pe * ce;
            end
            q = (sum + (SUM_W'(1) <<< (COEF_FRAC - 1))) >>> COEF_FRAC;
        end

        // Saturate to the unsigned pixel range
        always_comb begin
            if (q < 0)
                result[c*PIX_W +: PIX_W] = '0;
            else if (q > $signed(SUM_W'((1 << PIX_W) - 1)))
                result[c*PIX_W +: PIX_W] = '1;
            else
                result[c*PIX_W +: PIX_W] = q[PIX_W-1:0];
        end
    end

endmodule

// File: rtl/vert_poly_scaler.sv
// Module: streaming vertical polyphase scaler (top).
// Alternates between taking one input line and emitting one output line.
// An output line is emitted once its whole source window is stored and
// at least min(TAPS, lines) lines have arrived. A fixed pause follows
// each input line; the first frame after reset waits for the coefficient copy.
// Assumes: all lines of a frame have the same length (1..MAX_W), every
// frame starts with s_sof, and cfg_step keeps centres inside the frame.
module vert_poly_scaler #(
    parameter int PIX_W     = 8,
    parameter int COMP      = 3,
    parameter int TAPS      = 6,
    parameter int PHASES    = 64,
    parameter int MAX_W     = 64,
    parameter int DIM_W     = 11,
    parameter int FRAC_W    = 16,
    parameter int COEF_W    = 16,
    parameter int COEF_FRAC = 12,
    parameter int GAP       = 20,
    localparam int CA_W     = $clog2(PHASES * TAPS + 1),
    localparam int ACC_W    = DIM_W + FRAC_W,
    localparam int DATA_W   = PIX_W * COMP
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              coef_wr_en,
    input  logic [CA_W-1:0]   coef_wr_addr,
    input  logic [COEF_W-1:0] coef_wr_data,
    input  logic [DIM_W-1:0]  cfg_in_lines,
    input  logic [DIM_W-1:0]  cfg_out_lines,
    input  logic [ACC_W-1:0]  cfg_step,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [DATA_W-1:0] s_data,
    input  logic              s_sof,
    input  logic              s_eol,
    output logic              m_valid,
    input  logic              m_ready,
    output logic [DATA_W-1:0] m_data,
    output logic              m_sof,
    output logic              m_eol
);
    import vsc_pkg::*;

    localparam int PH_W   = $clog2(PHASES);
    localparam int SLOT_W = $clog2(TAPS);
    localparam int X_W    = $clog2(MAX_W + 1);
    localparam int GAP_W  = $clog2(GAP + 1);
    localparam int HALF   = TAPS / 2;

    vsc_state_e          state;
    logic                loaded;
    logic [DIM_W-1:0]    h_in, h_out, n_in, j;
    logic [ACC_W-1:0]    step, acc;
    logic [X_W-1:0]      col, line_w, x;
    logic [SLOT_W-1:0]   wr_slot;
    logic [GAP_W-1:0]    gap_cnt;

    logic                copy_start, copy_busy, copy_last;
    logic                frame_go, in_fire, lb_we, out_adv, last_px, win_ok;
    logic [PH_W-1:0]     phase;
    logic [TAPS*SLOT_W-1:0] rd_slots;
    logic [TAPS*DATA_W-1:0] win_pix;
    logic [TAPS*COEF_W-1:0] win_coef;
    logic [DATA_W-1:0]   filt;

    assign s_ready    = (state == ST_IN);
    assign in_fire    = s_ready && s_valid;
    assign frame_go   = (state == ST_IDLE) && s_valid && s_sof && !m_valid;
    assign copy_start = frame_go && !loaded;
    assign lb_we      = in_fire && (int'(col) < MAX_W);
    assign out_adv    = (state == ST_OUT) && (!m_valid || m_ready);
    assign last_px    = (x == line_w - X_W'(1));
    assign phase      = acc[FRAC_W-1 -: PH_W];

    // Source rows for every tap, replicated at the frame edges
    always_comb begin
        int ai;
        int r;
        ai = int'(acc[ACC_W-1:FRAC_W]);
        for (int t = 0; t < TAPS; t++) begin
            r = vsc_clamp_row(ai - (HALF - 1) + t, int'(h_in));
            rd_slots[t*SLOT_W +: SLOT_W] = SLOT_W'(r % TAPS);
        end
    end

    // Window readiness: last needed row stored and startup depth reached
    always_comb begin
        int mx;
        int st;
        mx = vsc_clamp_row(int'(acc[ACC_W-1:FRAC_W]) + HALF, int'(h_in));
        st = (TAPS < int'(h_in)) ? TAPS : int'(h_in);
        win_ok = (mx < int'(n_in)) && (int'(n_in) >= st);
    end

    // Frame control, input bookkeeping and phase accumulator
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            loaded  <= 1'b0;
            h_in    <= '0;
            h_out   <= '0;
            step    <= '0;
            n_in    <= '0;
            j       <= '0;
            acc     <= '0;
            col     <= '0;
            line_w  <= '0;
            x       <= '0;
            wr_slot <= '0;
            gap_cnt <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (frame_go) begin
                        h_in    <= cfg_in_lines;
                        h_out   <= cfg_out_lines;
                        step    <= cfg_step;
                        n_in    <= '0;
                        j       <= '0;
                        acc     <= '0;
                        col     <= '0;
                        wr_slot <= '0;
                        state   <= loaded ? ST_IN : ST_COPY;
                    end
                end
                ST_COPY: begin
                    if (copy_last) begin
                        loaded <= 1'b1;
                        state  <= ST_IN;
                    end
                end
                ST_IN: begin
                    if (in_fire) begin
                        if (s_eol) begin
                            line_w  <= (int'(col) < MAX_W) ? col + X_W'(1) : X_W'(MAX_W);
                            col     <= '0;
                            n_in    <= n_in + DIM_W'(1);
                            wr_slot <= (wr_slot == SLOT_W'(TAPS - 1)) ? '0 : wr_slot + SLOT_W'(1);
                            gap_cnt <= GAP_W'(GAP - 1);
                            state   <= ST_GAP;
                        end else if (int'(col) < MAX_W) begin
                            col <= col + X_W'(1);
                        end
                    end
                end
                ST_GAP: begin
                    if (gap_cnt == '0) state <= ST_DEC;
                    else               gap_cnt <= gap_cnt - GAP_W'(1);
                end
                ST_DEC: begin
                    if ((j < h_out) && win_ok) begin
                        x     <= '0;
                        state <= ST_OUT;
                    end else if (n_in < h_in) begin
                        state <= ST_IN;
                    end else begin
                        state <= ST_IDLE;
                    end
                end
                ST_OUT: begin
                    if (out_adv) begin
                        if (last_px) begin
                            j     <= j + DIM_W'(1);
                            acc   <= acc + step;
                            state <= ST_DEC;
                        end else begin
                            x <= x + X_W'(1);
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Output register: load on advance, hold while stalled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_valid <= 1'b0;
            m_data  <= '0;
            m_sof   <= 1'b0;
            m_eol   <= 1'b0;
        end else if (!m_valid || m_ready) begin
            m_valid <= (state == ST_OUT);
            if (state == ST_OUT) begin
                m_data <= filt;
                m_sof  <= (j == '0) && (x == '0);
                m_eol  <= last_px;
            end
        end
    end

    vsc_coef_store #(
        .TAPS(TAPS), .PHASES(PHASES), .COEF_W(COEF_W), .CA_W(CA_W), .PH_W(PH_W)
    ) u_coef (
        .clk(clk), .rst_n(rst_n),
        .wr_en(coef_wr_en), .wr_addr(coef_wr_addr), .wr_data(coef_wr_data),
        .copy_start(copy_start), .copy_busy(copy_busy), .copy_last(copy_last),
        .rd_phase(phase), .rd_coefs(win_coef)
    );

    vsc_line_buf #(
        .DATA_W(DATA_W), .TAPS(TAPS), .MAX_W(MAX_W), .SLOT_W(SLOT_W), .X_W(X_W)
    ) u_lines (
        .clk(clk), .rst_n(rst_n),
        .wr_en(lb_we), .wr_slot(wr_slot), .wr_col(col), .wr_data(s_data),
        .rd_slots(rd_slots), .rd_col(x), .rd_data(win_pix)
    );

    vsc_filter #(
        .PIX_W(PIX_W), .COMP(COMP), .TAPS(TAPS), .COEF_W(COEF_W), .COEF_FRAC(COEF_FRAC)
    ) u_filt (
        .pix(win_pix), .coefs(win_coef), .result(filt)
    );

    // R2: no pixel accepted while the coefficient copy runs
    a_r2_ready_low_while_copying: assert property (@(posedge clk) disable iff (!rst_n)
        copy_busy |-> !s_ready);

    // R3: the bookkeeping pause keeps the input closed
    a_r3_gap_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_cnt != '0) |-> !s_ready);

    // R4: the first output pixel waits for the startup depth
    a_r4_no_early_sof: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_sof) |-> ((int'(n_in) >= TAPS) || (n_in == h_in)));

    // R8: a stalled output stays put
    a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_sof) && $stable(m_eol)));

    // R10: once loaded, the copy never runs again
    a_r10_single_copy: assert property (@(posedge clk) disable iff (!rst_n)
        loaded |-> !copy_busy);

endmodule

// File: tb/sim_vert_poly_scaler.sv
// Bench: random pixels, weights and handshakes with a fixed seed plus
// directed frames (short frame, one-pixel lines, extreme pixels);
// every output pixel is compared against a bench-side model.
module sim_vert_poly_scaler;
    localparam int TAPS = 6;
    localparam int PHASES = 64;
    localparam int NCOEF = TAPS * PHASES;
    localparam int GAP = 20;
    localparam int CYC_LIMIT = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic coef_wr_en = 1'b0;
    logic [8:0] coef_wr_addr = '0;
    logic [15:0] coef_wr_data = '0;
    logic [10:0] cfg_in_lines = '0, cfg_out_lines = '0;
    logic [26:0] cfg_step = '0;
    logic s_valid = 1'b0, s_sof = 1'b0, s_eol = 1'b0, m_ready = 1'b0;
    logic [23:0] s_data = '0;
    logic s_ready, m_valid, m_sof, m_eol;
    logic [23:0] m_data;

    int total = 0, bad = 0, cyc = 0;
    int cf [NCOEF];
    logic [23:0] img [256];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    vert_poly_scaler u0 (
        .clk(clk), .rst_n(rst_n),
        .coef_wr_en(coef_wr_en), .coef_wr_addr(coef_wr_addr), .coef_wr_data(coef_wr_data),
        .cfg_in_lines(cfg_in_lines), .cfg_out_lines(cfg_out_lines), .cfg_step(cfg_step),
        .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_sof(s_sof), .s_eol(s_eol),
        .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_sof(m_sof), .m_eol(m_eol)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // Write a weight set to the register bank; model keeps set A only
    task automatic write_coefs(input bit keep);
        for (int i = 0; i < NCOEF; i++) begin
            int v;
            v = int'($urandom_range(0, 2000)) - 500;
            if (keep) cf[i] = v;
            @(negedge clk);
            coef_wr_en = 1'b1;
            coef_wr_addr = 9'(i);
            coef_wr_data = 16'(v);
        end
        @(negedge clk);
        coef_wr_en = 1'b0;
    endtask

    function automatic int clamp_row(input int r, input int h);
        if (r > h - 1) r = h - 1;
        if (r < 0) r = 0;
        return r;
    endfunction

    // Expected pixel from R5, R6, R7
    function automatic logic [23:0] exp_pix(input int jj, input int xx, input int w, input int h, input int st);
        logic [23:0] res;
        longint a;
        int ai, ph;
        a = longint'(jj) * st;
        ai = int'(a >> 16);
        ph = int'((a >> 10) & 63);
        for (int c = 0; c < 3; c++) begin
            int s, q;
            s = 0;
            for (int t = 0; t < TAPS; t++) begin
                int r;
                r = clamp_row(ai - (TAPS / 2 - 1) + t, h);
                s += int'((img[r * w + xx] >> (8 * c)) & 24'hff) * cf[ph * TAPS + t];
            end
            q = (s + 2048) >>> 12;
            if (q < 0) q = 0;
            if (q > 255) q = 255;
            res[c*8 +: 8] = 8'(q);
        end
        return res;
    endfunction

    task automatic run_frame(input int w, input int h, input int oh, input bit first,
                             input bit extreme, input string tag);
        int st, in_idx, out_idx, tin, tout, lines_in, copy_low, gap_low, t0;
        bit gap_armed, first_seen, prev_stall;
        logic [25:0] prev_out;
        st = (h * 65536) / oh;
        for (int i = 0; i < w * h; i++)
            img[i] = extreme ? {($urandom % 2) ? 8'hff : 8'h00, ($urandom % 2) ? 8'hff : 8'h00,
                                ($urandom % 2) ? 8'hff : 8'h00} : 24'($urandom);
        @(negedge clk);
        cfg_in_lines = 11'(h);
        cfg_out_lines = 11'(oh);
        cfg_step = 27'(st);
        in_idx = 0; out_idx = 0; tin = w * h; tout = w * oh;
        lines_in = 0; copy_low = 0; gap_low = 0; gap_armed = 0;
        first_seen = 0; prev_stall = 0; prev_out = '0; t0 = cyc;
        while ((out_idx < tout || in_idx < tin) && (cyc - t0) < 20000 && cyc < CYC_LIMIT) begin
            @(negedge clk);
            if (in_idx < tin) begin
                s_valid = (in_idx == 0) ? 1'b1 : (($urandom % 5) != 0);
                s_data = img[in_idx];
                s_sof = (in_idx == 0);
                s_eol = ((in_idx % w) == w - 1);
            end else begin
                s_valid = 1'b0; s_sof = 1'b0; s_eol = 1'b0;
            end
            m_ready = (($urandom % 4) != 0);
            #1;
            if (prev_stall)  // R8 held output
                check(m_valid && {m_sof, m_eol, m_data} == prev_out, "R8 stall hold",
                      {m_valid, m_sof, m_eol, m_data}, {1'b1, prev_out});
            if (first && in_idx == 0 && !s_ready) copy_low++;
            if (gap_armed) begin
                if (s_ready) begin
                    check(gap_low >= GAP, "R3 line gap", gap_low, GAP);
                    gap_armed = 0;
                end else gap_low++;
            end
            if (s_valid && s_ready) begin
                if (first && in_idx == 0)
                    check(copy_low >= NCOEF && copy_low <= NCOEF + 3, "R2 copy wait", copy_low, NCOEF);
                if (s_eol) begin
                    lines_in++;
                    gap_armed = 1;
                    gap_low = 0;
                end
                in_idx++;
            end
            if (m_valid && !first_seen) begin
                check(lines_in >= ((h < TAPS) ? h : TAPS), "R4 startup depth", lines_in, (h < TAPS) ? h : TAPS);
                first_seen = 1;
            end
            if (m_valid && m_ready) begin
                int jj, xx;
                logic [23:0] e;
                jj = out_idx / w;
                xx = out_idx % w;
                if (out_idx < tout) begin
                    e = exp_pix(jj, xx, w, h, st);
                    check(m_data == e, tag, m_data, e);
                    check(m_sof == (out_idx == 0) && m_eol == (xx == w - 1), "R9 markers",
                          {m_sof, m_eol}, {out_idx == 0, xx == w - 1});
                end else
                    check(1'b0, "R9 extra pixel", out_idx, tout);
                out_idx++;
            end
            prev_stall = m_valid && !m_ready;
            prev_out = {m_sof, m_eol, m_data};
        end
        check(out_idx == tout && in_idx == tin, "R9 pixel count", out_idx, tout);
        @(negedge clk);
        s_valid = 1'b0; s_sof = 1'b0; s_eol = 1'b0; m_ready = 1'b1;
        repeat (40) begin
            @(negedge clk);
            #1;
            if (m_valid) check(1'b0, "R9 no extra output", 1, 0);
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(!s_ready && !m_valid, "R1 reset state", {s_ready, m_valid}, 0);
        write_coefs(1'b1);
        run_frame(8, 10, 14, 1'b1, 1'b0, "R5 upscale pixel");
        write_coefs(1'b0);  // later writes must not matter (R10)
        run_frame(6, 12, 7, 1'b0, 1'b0, "R5 downscale pixel");
        run_frame(8, 10, 14, 1'b0, 1'b0, "R10 stale weights pixel");
        run_frame(5, 3, 5, 1'b0, 1'b0, "R7 short frame edge pixel");
        run_frame(1, 7, 3, 1'b0, 1'b1, "R6 clamp one-pixel line");
        if (cyc >= CYC_LIMIT) check(1'b0, "watchdog", cyc, CYC_LIMIT);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog for a hung handshake
    initial begin
        #(8 * (CYC_LIMIT + 20000));
        bad++; total++;
        $display("FAIL watchdog act=%0d exp=%0d", cyc, CYC_LIMIT);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule